// File: doc/BRIEF.md
# Wake-Up Input Detector and Status

This block monitors four external wake-up lines while the chip sits in a low-power mode. The lines form two pairs, and each pair has its own programmable sensitivity. When a line meets its pair's setting during Sleep or Stop, the block raises a one-cycle wake request. It also records which lines caused the wake so that software can read them later.

The status register behaves in two ways. After a wake, it holds the recorded source until the first read. From then on, and at any time in Normal or Standby, it shows the live level of each line. A watchdog expiry that arrives after a wake out of Stop, and before that first read, discards the recorded source. The same expiry after a wake out of Sleep leaves the recorded source in place.

No data stream passes through this block, so it has no valid/ready interface and no back-pressure. Every pin is a plain level or a single-cycle strobe, and each is sampled on the rising clock edge.

Top module: `wake_detect_top`

## Requirements
- R1: A synchronous active-high reset sets both sensitivity fields to 00, clears the recorded source and the pending-read flag, and holds `wake_req` low.
- R2: Each line passes through a two-stage synchronizer. In Normal mode, a level change shows on `rd_data` after exactly two rising edges.
- R3: Sensitivity code 00 disables both lines of its pair. A disabled line never wakes the chip and never sets its status bit.
- R4: Code 01 makes a line match while it is high.
- R5: Code 10 makes a line match while it is low.
- R6: Code 11 makes a line match at either level.
- R7: `wake_req` is a single-cycle pulse. It appears one edge after a matching line is seen in Sleep (`pwr_mode`=10) or Stop (`pwr_mode`=11), and it never appears in Normal (00) or Standby (01). Only one pulse is given per wake until the status has been read.
- R8: At a wake, the status bits of the matching lines read 1 and all others read 0. Bit i of `rd_data` belongs to line i. In a low-power mode with no wake recorded, `rd_data` reads 0.
- R9: In Normal or Standby with no wake pending, `rd_data` bit i equals the synchronized level of line i (1 = high).
- R10: The first `rd_stb` after a wake returns the recorded source and clears the pending flag. Any later read returns the live levels of that same cycle.
- R11: A `wdt_expire` pulse after a wake from Stop, and before the first read, clears the recorded source and the pending flag.
- R12: A `wdt_expire` pulse after a wake from Sleep has no effect on the recorded source.
- R13: A reset while a wake is pending drops the recorded source. `rd_data` then shows live synchronized levels.
- R14: A write with `cfg_sel`=0 programs the field for lines 0 and 1. A write with `cfg_sel`=1 programs the field for lines 2 and 3. Encodings are as in R3 to R6, and a write takes effect on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wk_in | input | 4 | Asynchronous wake-up line levels |
| pwr_mode | input | 2 | 00 Normal, 01 Standby, 10 Sleep, 11 Stop |
| cfg_we | input | 1 | Sensitivity field write strobe |
| cfg_sel | input | 1 | Field select: 0 = lines 0/1, 1 = lines 2/3 |
| cfg_data | input | 2 | Sensitivity code to write |
| rd_stb | input | 1 | Status read strobe |
| rd_data | output | 4 | Status bits, one per line |
| wdt_expire | input | 1 | Watchdog time-out pulse |
| wake_req | output | 1 | One-cycle wake request |

## Verification
Several rules are checked by assertions on every cycle. The wake pulse lasts one cycle and occurs only after a low-power mode with at least one enabled field. A first read drops the pending flag. A Stop-mode watchdog expiry empties the recorded source, and a Sleep-mode expiry leaves it untouched. Other behaviours can only be shown by bench scenarios. These are the match produced by each sensitivity code on each pair, the two-edge synchronizer latency, the switch from recorded source to live levels, and the effect of a reset in the middle of a pending wake.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  typedef enum logic [1:0] {
    SENS_OFF  = 2'b00,
    SENS_HIGH = 2'b01,
    SENS_LOW  = 2'b10,
    SENS_ANY  = 2'b11
  } sens_t;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_STANDBY = 2'b01,
    MODE_SLEEP   = 2'b10,
    MODE_STOP    = 2'b11
  } pmode_t;
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d_async;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/wkup_match.sv
module wkup_match
  import wkup_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int GRP   = 2,
  localparam int N_GRP = N_IN / GRP
) (
  input  logic [N_GRP-1:0][1:0] cfg,
  input  logic [N_IN-1:0]       lvl,
  output logic [N_IN-1:0]       hit
);
  for (genvar i = 0; i < N_IN; i++) begin : g_in
    localparam int G = i / GRP;
    always_comb begin
      case (sens_t'(cfg[G]))
        SENS_HIGH: hit[i] = lvl[i];
        SENS_LOW:  hit[i] = ~lvl[i];
        SENS_ANY:  hit[i] = 1'b1;
        default:   hit[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/wkup_status.sv
module wkup_status #(
  parameter int N_IN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            low_power,
  input  logic            in_stop,
  input  logic [N_IN-1:0] hit,
  input  logic [N_IN-1:0] lvl,
  input  logic            rd_stb,
  input  logic            wdt,
  output logic [N_IN-1:0] rd_data,
  output logic            wake_req
);
  logic [N_IN-1:0] latched;
  logic            pending;
  logic            from_stop;
  logic            wake_q;
  logic            wake_evt;

  assign wake_evt = low_power && !pending && (|hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      latched   <= '0;
      pending   <= 1'b0;
      from_stop <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      wake_q <= wake_evt;
      if (wake_evt) begin
        latched   <= hit;
        pending   <= 1'b1;
        from_stop <= in_stop;
      end else begin
        if (pending && rd_stb) pending <= 1'b0;
        if (pending && from_stop && wdt) begin
          latched <= '0;
          pending <= 1'b0;
        end
      end
    end
  end

  assign rd_data  = pending ? latched : (low_power ? '0 : lvl);
  assign wake_req = wake_q;

  // R7
  wake_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wake_req |=> !wake_req);

  // R10
  first_read_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && rd_stb) |=> !pending);

  // R11
  stop_wdt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && from_stop && wdt) |=> (!pending && latched == '0));

  // R12
  sleep_wdt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && !from_stop && wdt && !rd_stb) |=> (pending && $stable(latched)));

  // R8
  src_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> (latched != '0));
endmodule

// File: rtl/wake_detect_top.sv
module wake_detect_top
  import wkup_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int GRP    = 2,
  parameter int STAGES = 2,
  localparam int N_GRP = N_IN / GRP,
  localparam int SEL_W = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  wk_in,
  input  logic [1:0]       pwr_mode,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [1:0]       cfg_data,
  input  logic             rd_stb,
  output logic [N_IN-1:0]  rd_data,
  input  logic             wdt_expire,
  output logic             wake_req
);
  logic [N_GRP-1:0][1:0] cfg_q;
  logic [N_IN-1:0]       lvl_s;
  logic [N_IN-1:0]       hit;
  logic                  low_power;
  logic                  in_stop;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (cfg_we) cfg_q[cfg_sel] <= cfg_data;
  end

  assign low_power = (pmode_t'(pwr_mode) == MODE_SLEEP) || (pmode_t'(pwr_mode) == MODE_STOP);
  assign in_stop   = (pmode_t'(pwr_mode) == MODE_STOP);

  wkup_sync #(.W(N_IN), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(wk_in), .d_sync(lvl_s)
  );

  wkup_match #(.N_IN(N_IN), .GRP(GRP)) u_match (
    .cfg(cfg_q), .lvl(lvl_s), .hit(hit)
  );

  wkup_status #(.N_IN(N_IN)) u_status (
    .clk(clk), .rst(rst), .low_power(low_power), .in_stop(in_stop),
    .hit(hit), .lvl(lvl_s), .rd_stb(rd_stb), .wdt(wdt_expire),
    .rd_data(rd_data), .wake_req(wake_req)
  );

  // R7
  wake_mode_chk: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(pwr_mode[1]));

  // R3
  wake_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(cfg_q != '0));
endmodule

// File: tb/test_wake_detect_top.sv
module test_wake_detect_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] wk_in;
  logic [1:0] pwr_mode;
  logic       cfg_we;
  logic [0:0] cfg_sel;
  logic [1:0] cfg_data;
  logic       rd_stb;
  logic [3:0] rd_data;
  logic       wdt_expire;
  logic       wake_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_detect_top i_wake_detect_top (
    .clk(clk), .rst(rst), .wk_in(wk_in), .pwr_mode(pwr_mode),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .rd_stb(rd_stb), .rd_data(rd_data), .wdt_expire(wdt_expire),
    .wake_req(wake_req)
  );

  function automatic logic [3:0] f_hit(logic [1:0] a, logic [1:0] b, logic [3:0] lv);
    logic [3:0] h;
    for (int i = 0; i < 4; i++) begin
      logic [1:0] s;
      s = (i < 2) ? a : b;
      case (s)
        2'b01:   h[i] = lv[i];
        2'b10:   h[i] = ~lv[i];
        2'b11:   h[i] = 1'b1;
        default: h[i] = 1'b0;
      endcase
    end
    return h;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(logic [1:0] a, logic [1:0] b);
    cfg_we = 1; cfg_sel = 0; cfg_data = a; cyc(1);
    cfg_sel = 1; cfg_data = b; cyc(1);
    cfg_we = 0;
  endtask

  task automatic to_normal_clear();
    pwr_mode = 2'b00; rd_stb = 1; cyc(1); rd_stb = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; wk_in = 0; pwr_mode = 0; cfg_we = 0; cfg_sel = 0; cfg_data = 0;
    rd_stb = 0; wdt_expire = 0;
    cyc(3); rst = 0; #1;
    // R1 reset state
    chk("R1 rd_data", rd_data, 4'h0);
    chk("R1 wake_req", wake_req, 0);
    pwr_mode = 2'b10; cyc(3); #1;
    chk("R1 no wake with reset cfg", wake_req, 0);
    chk("R3 status zero when disabled", rd_data, 4'h0);
    pwr_mode = 2'b00; cyc(1);

    // R2 synchronizer latency
    wk_in = 4'b1010; cyc(1); #1;
    chk("R2 one edge old", rd_data, 4'h0);
    cyc(1); #1;
    chk("R2 two edges new", rd_data, 4'b1010);

    // R14 R4 R5 pair fields
    wr_cfg(2'b01, 2'b10);
    wk_in = 4'b0001; cyc(3);
    pwr_mode = 2'b10; cyc(1); #1;
    chk("R14 R4 R5 wake", wake_req, 1);
    chk("R14 R4 R5 source", rd_data, 4'b1101);
    cyc(1); #1;
    chk("R7 single pulse", wake_req, 0);
    cyc(2); #1;
    chk("R7 no repeat while pending", wake_req, 0);
    pwr_mode = 2'b00; rd_stb = 1; #1;
    chk("R10 first read latched", rd_data, 4'b1101);
    cyc(1); #1;
    chk("R10 later read live", rd_data, 4'b0001);
    rd_stb = 0;

    // R6 either level
    wr_cfg(2'b11, 2'b00);
    wk_in = 4'b0010; cyc(3);
    pwr_mode = 2'b11; cyc(1); #1;
    chk("R6 source", rd_data, 4'b0011);
    to_normal_clear();

    // R11 watchdog in Stop
    wr_cfg(2'b01, 2'b00);
    wk_in = 4'b0001; cyc(3);
    pwr_mode = 2'b11; cyc(1); #1;
    chk("R11 stop wake source", rd_data, 4'b0001);
    wk_in = 4'b0000; cyc(3);
    wdt_expire = 1; cyc(1); wdt_expire = 0; #1;
    chk("R11 cleared in stop", rd_data, 4'h0);
    pwr_mode = 2'b00; #1;
    chk("R11 live after clear", rd_data, 4'h0);
    cyc(1);

    // R12 watchdog in Sleep
    wk_in = 4'b0001; cyc(3);
    pwr_mode = 2'b10; cyc(1);
    wk_in = 4'b0000; cyc(3);
    wdt_expire = 1; cyc(1); wdt_expire = 0; #1;
    chk("R12 held in sleep", rd_data, 4'b0001);
    pwr_mode = 2'b00; rd_stb = 1; #1;
    chk("R12 first read latched", rd_data, 4'b0001);
    cyc(1); rd_stb = 0; #1;
    chk("R12 live after read", rd_data, 4'h0);

    // R13 reset while pending
    wk_in = 4'b0001; cyc(3);
    pwr_mode = 2'b11; cyc(1); #1;
    chk("R13 pending before reset", rd_data, 4'b0001);
    rst = 1; cyc(1); rst = 0; pwr_mode = 2'b00; #1;
    chk("R13 source dropped", rd_data, 4'h0);
    cyc(3); #1;
    chk("R13 live resync", rd_data, 4'b0001);

    // random phase: R3 R4 R5 R6 R7 R8 R9 R10
    for (int it = 0; it < 60; it++) begin
      logic [1:0] a, b;
      logic [3:0] lv, exp;
      logic [1:0] md;
      a = 2'($urandom()); b = 2'($urandom()); lv = 4'($urandom());
      md = {1'b1, 1'($urandom())};
      exp = f_hit(a, b, lv);
      to_normal_clear();
      wr_cfg(a, b);
      wk_in = lv; pwr_mode = 2'($urandom() & 1); cyc(3); #1;
      chk("R9 live level", rd_data, lv);
      pwr_mode = md; #1;
      chk("R8 no wake yet reads zero", rd_data, 4'h0);
      cyc(1); #1;
      chk("R7 wake pulse", wake_req, exp != 0);
      chk("R8 R3 R4 R5 R6 source", rd_data, exp);
      cyc(1); #1;
      chk("R7 pulse ends", wake_req, 0);
      pwr_mode = 2'b00; rd_stb = 1; #1;
      chk("R10 first read", rd_data, (exp != 0) ? exp : lv);
      cyc(1); #1;
      chk("R10 second read live", rd_data, lv);
      rd_stb = 0;
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule